// File: doc/BRIEF.md
# Home Directory Controller for Cluster Cache Coherence

This block is the home side of a directory-based coherence scheme for a group of memory lines that several clusters may cache. For every line it keeps a stable state (Uncached, Shared or Modified), a presence vector with one bit per cluster, and the bookkeeping of a single in-flight transaction: who asked, whether exclusive access was asked for, whether the line waits for invalidation acknowledgements or for a writeback from the owner, and how many acknowledgements remain. A small line memory holds the home copy of each line's data.

Clusters send read and read-exclusive requests on a request port. Acknowledgements and writebacks come in on a message port, which has priority: in a cycle with a message, the request is not taken and `req_ready` is low, so the requester holds it. Every taken event may produce one registered output message one cycle later: a data reply, an invalidate, a fetch sent to the current owner, or a retry. Invalidates and fetches carry a destination mask, so a single message reaches every sharer.

Ownership is explicit: the home owns an Uncached or Shared line, and the one cluster present in a Modified line owns it. Exclusive access is granted only after every other copy has been removed.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every line is Uncached with an empty presence vector and all line data is zero; `out_valid` is low until an event is taken.
- R2: A read of an Uncached or Shared line returns a data reply (kind 0) to the requester one cycle after it is taken, carrying the home data; the line becomes Shared and the requester's presence bit is set.
- R3: A read-exclusive of an Uncached line, or of a Shared line whose only sharer is the requester, returns a data reply at once and makes the requester the sole present cluster of a Modified line.
- R4: A read-exclusive of a Shared line with other sharers sends one invalidate (kind 1) whose mask holds every other sharer and not the requester; each acknowledgement counts down, and only the last one produces the data reply to the requester, leaving it sole owner of a Modified line.
- R5: A request for a Modified line sends a fetch (kind 2) whose mask is exactly the owner's bit, and the line waits for the owner's writeback.
- R6: The owner's writeback of a fetched line stores its data and replies to the waiting requester with that data; after a read the line is Shared with owner and requester present, after a read-exclusive it is Modified with only the requester present.
- R7: A request to a line with a transaction in progress is answered with a retry (kind 3) to the requester and changes nothing.
- R8: A writeback from the owner of a stable Modified line stores the data, leaves the line Uncached with an empty presence vector, and produces no output.
- R9: When a message and a request arrive in the same cycle, the message is processed, `req_ready` is low, and the request is neither answered nor applied.
- R10: An acknowledgement to a line not waiting for acknowledgements, and a writeback from a cluster that is not the owner of a Modified line, produce no output and change nothing.
- R11: Output destinations are masks with bit i meaning cluster i; a data reply or retry has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_excl | input | 1 | 1 = read-exclusive, 0 = read |
| req_src | input | CW | Requesting cluster |
| req_line | input | LW | Line index |
| req_ready | output | 1 | Request taken this cycle when high (low while a message arrives) |
| msg_valid | input | 1 | Message present |
| msg_wb | input | 1 | 1 = writeback, 0 = invalidation acknowledgement |
| msg_src | input | CW | Sending cluster |
| msg_line | input | LW | Line index |
| msg_data | input | DATA_W | Writeback data |
| out_valid | output | 1 | Output message present |
| out_kind | output | 2 | 0 data, 1 invalidate, 2 fetch, 3 retry |
| out_dest | output | N_CLUSTERS | Destination mask |
| out_line | output | LW | Line index |
| out_data | output | DATA_W | Line data (meaningful for data replies) |

## Verification
The two functions that meet in one cycle are message handling and request handling: an acknowledgement or writeback arriving together with a request, possibly on the same line. The bench provokes this with a directed collision and with a random phase in which both ports fire often on four lines. A behavioural per-line model decides, in every cycle, that the message alone took effect, that `req_ready` was low, and that the held request was served later from the state the message left.

// File: rtl/dir_pkg.sv
`timescale 1ns/1ps
package dir_pkg;

  typedef enum logic [1:0] {
    LN_UNCACHED = 2'd0,
    LN_SHARED   = 2'd1,
    LN_MODIFIED = 2'd2
  } line_state_e;

  typedef enum logic [1:0] {
    OUT_DATA  = 2'd0,
    OUT_INVAL = 2'd1,
    OUT_FETCH = 2'd2,
    OUT_RETRY = 2'd3
  } out_kind_e;

  function automatic int unsigned count_ones(input logic [63:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 64; i++) n += int'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/dir_line_mem.sv
`timescale 1ns/1ps
module dir_line_mem #(
  parameter int N_LINES = 16,
  parameter int DATA_W  = 32,
  localparam int LW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LW-1:0]     addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [N_LINES];

  initial begin
    for (int i = 0; i < N_LINES; i++) mem[i] = '0;
  end

  // single port, write-first: a reply in the cycle of a writeback sees the new data
  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
      rdata     <= wdata;
    end else begin
      rdata <= mem[addr];
    end
  end

  AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (rst)
    we |=> rdata == $past(wdata)); // R6

endmodule

// File: rtl/dir_entry_table.sv
`timescale 1ns/1ps
module dir_entry_table #(
  parameter int N_LINES = 16,
  parameter int ENTRY_W = 16,
  localparam int LW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LW-1:0]      addr,
  input  logic               we,
  input  logic [ENTRY_W-1:0] wdata,
  output logic [ENTRY_W-1:0] rdata
);

  logic [ENTRY_W-1:0] tbl [N_LINES];

  assign rdata = tbl[addr];

  // all-zero entry encodes Uncached, nobody present, idle
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_LINES; i++) tbl[i] <= '0;
    end else if (we) begin
      tbl[addr] <= wdata;
    end
  end

endmodule

// File: rtl/dir_home_ctrl.sv
`timescale 1ns/1ps
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int N_CLUSTERS = 4,
  parameter int N_LINES    = 16,
  parameter int DATA_W     = 32,
  localparam int CW = (N_CLUSTERS > 1) ? $clog2(N_CLUSTERS) : 1,
  localparam int LW = (N_LINES > 1) ? $clog2(N_LINES) : 1,
  localparam int KW = $clog2(N_CLUSTERS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_excl,
  input  logic [CW-1:0]         req_src,
  input  logic [LW-1:0]         req_line,
  output logic                  req_ready,
  input  logic                  msg_valid,
  input  logic                  msg_wb,
  input  logic [CW-1:0]         msg_src,
  input  logic [LW-1:0]         msg_line,
  input  logic [DATA_W-1:0]     msg_data,
  output logic                  out_valid,
  output logic [1:0]            out_kind,
  output logic [N_CLUSTERS-1:0] out_dest,
  output logic [LW-1:0]         out_line,
  output logic [DATA_W-1:0]     out_data
);

  typedef struct packed {
    logic [KW-1:0]         cnt;   // acknowledgements still due
    logic [CW-1:0]         psrc;  // waiting requester
    logic                  excl;  // waiting request is exclusive
    logic                  fwd;   // waiting for owner writeback (else for acks)
    logic                  busy;  // transaction in progress
    logic [N_CLUSTERS-1:0] pres;
    line_state_e           st;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);
  localparam logic [N_CLUSTERS-1:0] ONE = N_CLUSTERS'(1);

  logic                  take_msg, take_req;
  logic [LW-1:0]         sel_line;
  logic [CW-1:0]         sel_src;
  logic [N_CLUSTERS-1:0] src_bit, psrc_bit, others;
  logic [ENTRY_W-1:0]    cur_raw;
  entry_t                cur, nxt;
  logic                  ent_we, mem_we, o_valid;
  out_kind_e             o_kind;
  logic [N_CLUSTERS-1:0] o_dest;

  // messages win; a request waits while one is present
  assign take_msg  = msg_valid;
  assign take_req  = req_valid & ~msg_valid;
  assign req_ready = ~msg_valid;
  assign sel_line  = take_msg ? msg_line : req_line;
  assign sel_src   = take_msg ? msg_src : req_src;

  dir_entry_table #(.N_LINES(N_LINES), .ENTRY_W(ENTRY_W)) i_table (
    .clk   (clk),
    .rst   (rst),
    .addr  (sel_line),
    .we    (ent_we),
    .wdata (nxt),
    .rdata (cur_raw)
  );

  dir_line_mem #(.N_LINES(N_LINES), .DATA_W(DATA_W)) i_mem (
    .clk   (clk),
    .rst   (rst),
    .addr  (sel_line),
    .we    (mem_we),
    .wdata (msg_data),
    .rdata (out_data)
  );

  assign cur      = entry_t'(cur_raw);
  assign src_bit  = ONE << sel_src;
  assign psrc_bit = ONE << cur.psrc;
  assign others   = cur.pres & ~src_bit;

  always_comb begin
    nxt     = cur;
    ent_we  = 1'b0;
    mem_we  = 1'b0;
    o_valid = 1'b0;
    o_kind  = OUT_DATA;
    o_dest  = '0;
    if (take_msg) begin
      if (!msg_wb) begin
        // invalidation acknowledgement
        if (cur.busy && !cur.fwd && cur.cnt != '0) begin
          ent_we  = 1'b1;
          nxt.cnt = cur.cnt - KW'(1);
          if (cur.cnt == KW'(1)) begin
            nxt.busy = 1'b0;
            nxt.st   = LN_MODIFIED;
            nxt.pres = psrc_bit;
            o_valid  = 1'b1;
            o_dest   = psrc_bit;
          end
        end
      end else if (cur.busy && cur.fwd && cur.pres[msg_src]) begin
        // owner answers a fetch
        mem_we   = 1'b1;
        ent_we   = 1'b1;
        nxt.busy = 1'b0;
        if (cur.excl) begin
          nxt.st   = LN_MODIFIED;
          nxt.pres = psrc_bit;
        end else begin
          nxt.st   = LN_SHARED;
          nxt.pres = cur.pres | psrc_bit;
        end
        o_valid = 1'b1;
        o_dest  = psrc_bit;
      end else if (!cur.busy && cur.st == LN_MODIFIED && cur.pres[msg_src]) begin
        // owner gives the line back
        mem_we   = 1'b1;
        ent_we   = 1'b1;
        nxt.st   = LN_UNCACHED;
        nxt.pres = '0;
      end
    end else if (take_req) begin
      o_valid = 1'b1;
      if (cur.busy) begin
        o_kind = OUT_RETRY;
        o_dest = src_bit;
      end else if (cur.st == LN_MODIFIED) begin
        o_kind   = OUT_FETCH;
        o_dest   = cur.pres;
        ent_we   = 1'b1;
        nxt.busy = 1'b1;
        nxt.fwd  = 1'b1;
        nxt.excl = req_excl;
        nxt.psrc = req_src;
      end else if (!req_excl) begin
        o_dest   = src_bit;
        ent_we   = 1'b1;
        nxt.st   = LN_SHARED;
        nxt.pres = cur.pres | src_bit;
      end else if (others == '0) begin
        o_dest   = src_bit;
        ent_we   = 1'b1;
        nxt.st   = LN_MODIFIED;
        nxt.pres = src_bit;
      end else begin
        o_kind   = OUT_INVAL;
        o_dest   = others;
        ent_we   = 1'b1;
        nxt.busy = 1'b1;
        nxt.fwd  = 1'b0;
        nxt.excl = 1'b1;
        nxt.psrc = req_src;
        nxt.cnt  = KW'(count_ones(64'(others)));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_kind  <= '0;
      out_dest  <= '0;
      out_line  <= '0;
    end else begin
      out_valid <= o_valid;
      out_kind  <= o_kind;
      out_dest  <= o_dest;
      out_line  <= sel_line;
    end
  end

  AST_REPLY_ONE_DEST: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_kind == OUT_DATA || out_kind == OUT_RETRY) |-> $countones(out_dest) == 1); // R11
  AST_BUSY_RETRIES: assert property (@(posedge clk) disable iff (rst)
    take_req && cur.busy |=> out_valid && out_kind == OUT_RETRY); // R7
  AST_INVAL_SKIPS_REQ: assert property (@(posedge clk) disable iff (rst)
    take_req && !cur.busy && req_excl && cur.st == LN_SHARED && others != '0
    |=> out_valid && out_kind == OUT_INVAL && !out_dest[$past(req_src)]); // R4
  AST_OWNER_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    take_msg || take_req |-> cur.st != LN_MODIFIED || $countones(cur.pres) == 1); // R5
  AST_STRAY_ACK_QUIET: assert property (@(posedge clk) disable iff (rst)
    take_msg && !msg_wb && !cur.busy |=> !out_valid); // R10
  AST_HELD_REQ_SILENT: assert property (@(posedge clk) disable iff (rst)
    msg_valid && req_valid |=> !(out_valid && out_kind == OUT_RETRY)); // R9

endmodule

// File: tb/test_dir_home_ctrl.sv
`timescale 1ns/1ps
module test_dir_home_ctrl;

  localparam int N  = 4;
  localparam int L  = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_excl = 0, msg_valid = 0, msg_wb = 0;
  logic [1:0] req_src = 0, msg_src = 0;
  logic [3:0] req_line = 0, msg_line = 0;
  logic [DW-1:0] msg_data = 0;
  logic req_ready, out_valid;
  logic [1:0] out_kind;
  logic [N-1:0] out_dest;
  logic [3:0] out_line;
  logic [DW-1:0] out_data;

  always #4 clk = ~clk;

  dir_home_ctrl #(.N_CLUSTERS(N), .N_LINES(L), .DATA_W(DW)) i_dir_home_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_excl(req_excl), .req_src(req_src), .req_line(req_line),
    .req_ready(req_ready),
    .msg_valid(msg_valid), .msg_wb(msg_wb), .msg_src(msg_src), .msg_line(msg_line),
    .msg_data(msg_data),
    .out_valid(out_valid), .out_kind(out_kind), .out_dest(out_dest),
    .out_line(out_line), .out_data(out_data)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural reference: 0 Uncached, 1 Shared, 2 Modified
  int        m_st  [L];
  bit [N-1:0] m_pres[L];
  bit        m_busy[L], m_fwd[L], m_excl[L];
  int        m_psrc[L], m_cnt[L];
  logic [DW-1:0] m_mem[L];
  bit        e_valid;
  int        e_kind, e_line;
  bit [N-1:0] e_dest;
  logic [DW-1:0] e_data;
  string     e_tag = "R1";

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int ones(input bit [N-1:0] v);
    int n = 0;
    for (int i = 0; i < N; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic model_req();
    int l = int'(req_line);
    int s = int'(req_src);
    bit [N-1:0] sb = N'(1) << s;
    bit [N-1:0] oth;
    e_valid = 1; e_line = l;
    if (m_busy[l]) begin
      e_kind = 3; e_dest = sb; e_tag = "R7";
    end else if (m_st[l] == 2) begin
      e_kind = 2; e_dest = m_pres[l]; e_tag = "R5";
      m_busy[l] = 1; m_fwd[l] = 1; m_excl[l] = req_excl; m_psrc[l] = s;
    end else if (!req_excl) begin
      e_kind = 0; e_dest = sb; e_data = m_mem[l]; e_tag = "R2";
      m_st[l] = 1; m_pres[l] |= sb;
    end else begin
      oth = m_pres[l] & ~sb;
      if (oth == 0) begin
        e_kind = 0; e_dest = sb; e_data = m_mem[l]; e_tag = "R3";
        m_st[l] = 2; m_pres[l] = sb;
      end else begin
        e_kind = 1; e_dest = oth; e_tag = "R4";
        m_busy[l] = 1; m_fwd[l] = 0; m_excl[l] = 1; m_psrc[l] = s; m_cnt[l] = ones(oth);
      end
    end
  endtask

  task automatic model_msg();
    int l = int'(msg_line);
    int s = int'(msg_src);
    bit [N-1:0] pb = N'(1) << m_psrc[l];
    e_line = l; e_tag = "R10";
    if (!msg_wb) begin
      if (m_busy[l] && !m_fwd[l] && m_cnt[l] > 0) begin
        m_cnt[l]--; e_tag = "R4";
        if (m_cnt[l] == 0) begin
          m_busy[l] = 0; m_st[l] = 2; m_pres[l] = pb;
          e_valid = 1; e_kind = 0; e_dest = pb; e_data = m_mem[l];
        end
      end
    end else if (m_busy[l] && m_fwd[l] && m_pres[l][s]) begin
      m_mem[l] = msg_data; m_busy[l] = 0;
      if (m_excl[l]) begin m_st[l] = 2; m_pres[l] = pb; end
      else begin m_st[l] = 1; m_pres[l] |= pb; end
      e_valid = 1; e_kind = 0; e_dest = pb; e_data = msg_data; e_tag = "R6";
    end else if (!m_busy[l] && m_st[l] == 2 && m_pres[l][s]) begin
      m_mem[l] = msg_data; m_st[l] = 0; m_pres[l] = '0; e_tag = "R8";
    end
    if (req_valid && !e_valid) e_tag = "R9";
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < L; i++) begin
        m_st[i] = 0; m_pres[i] = '0; m_busy[i] = 0; m_fwd[i] = 0; m_excl[i] = 0;
        m_psrc[i] = 0; m_cnt[i] = 0; m_mem[i] = '0;
      end
      e_valid = 0; e_tag = "R1";
    end else begin
      e_valid = 0; e_tag = "R1";
      if (msg_valid) model_msg();
      else if (req_valid) model_req();
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(req_ready === !msg_valid, "R9", "req_ready", longint'(req_ready), longint'(!msg_valid));
      chk(out_valid === e_valid, e_tag, "out_valid", longint'(out_valid), longint'(e_valid));
      if (out_valid === 1'b1 && e_valid) begin
        chk(int'(out_kind) == e_kind, e_tag, "out_kind", longint'(out_kind), longint'(e_kind));
        chk(out_dest === e_dest, e_tag, "out_dest", longint'(out_dest), longint'(e_dest));
        chk(int'(out_line) == e_line, e_tag, "out_line", longint'(out_line), longint'(e_line));
        if (e_kind == 0) begin
          chk(out_data === e_data, e_tag, "out_data", longint'(out_data), longint'(e_data));
          // R11: a data reply names one cluster
          chk(ones(out_dest) == 1, "R11", "reply dest count", longint'(ones(out_dest)), 1);
        end
      end
    end
  end

  task automatic put(input bit rv, input bit rx, input int rs, input int rl,
                     input bit mv, input bit mw, input int ms, input int ml,
                     input logic [DW-1:0] md);
    @(posedge clk); #2;
    req_valid = rv; req_excl = rx; req_src = 2'(rs); req_line = 4'(rl);
    msg_valid = mv; msg_wb = mw; msg_src = 2'(ms); msg_line = 4'(ml); msg_data = md;
  endtask

  task automatic idle(); put(0, 0, 0, 0, 0, 0, 0, 0, '0); endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 0;
    idle(); idle();                         // R1 quiet after reset
    put(1, 0, 0, 3, 0, 0, 0, 0, '0);         // R2 read uncached
    put(1, 0, 1, 3, 0, 0, 0, 0, '0);         // R2 read shared
    put(1, 1, 2, 3, 0, 0, 0, 0, '0);         // R4 invalidate c0,c1
    put(1, 0, 3, 3, 0, 0, 0, 0, '0);         // R7 retry while busy
    put(0, 0, 0, 0, 1, 0, 0, 3, '0);         // R4 first ack, no reply
    put(0, 0, 0, 0, 1, 0, 1, 3, '0);         // R4 last ack, reply to c2
    put(1, 0, 1, 3, 0, 0, 0, 0, '0);         // R5 fetch from c2
    put(0, 0, 0, 0, 1, 1, 2, 3, 32'h0000_A5A5); // R6 writeback, shared c1,c2
    put(1, 1, 1, 3, 0, 0, 0, 0, '0);         // R4 invalidate c2 only
    put(0, 0, 0, 0, 1, 0, 2, 3, '0);         // R4 ack, c1 owns
    put(0, 0, 0, 0, 1, 1, 1, 3, 32'h1234_5678); // R8 writeback to uncached
    put(1, 0, 0, 3, 0, 0, 0, 0, '0);         // R2 data read back
    put(1, 1, 0, 3, 0, 0, 0, 0, '0);         // R3 sole sharer upgrade
    put(1, 1, 2, 5, 0, 0, 0, 0, '0);         // R3 exclusive on uncached
    put(1, 1, 3, 5, 0, 0, 0, 0, '0);         // R5 fetch from c2
    put(0, 0, 0, 0, 1, 1, 2, 5, 32'h0000_0077); // R6 exclusive handoff to c3
    put(0, 0, 0, 0, 1, 0, 1, 7, '0);         // R10 stray ack
    put(0, 0, 0, 0, 1, 1, 0, 5, 32'hDEAD_0000); // R10 writeback from non-owner
    put(1, 0, 0, 5, 0, 0, 0, 0, '0);         // R5 owner still c3
    put(0, 0, 0, 0, 1, 1, 3, 5, 32'h0000_0099); // R6 read handoff
    put(1, 0, 1, 9, 1, 0, 0, 10, '0);        // R9 collision, request held
    put(1, 0, 1, 9, 0, 0, 0, 0, '0);         // R9 request taken afterwards
    idle();
    for (int k = 0; k < 600; k++) begin
      put($urandom_range(99) < 60, $urandom_range(1), $urandom_range(3), $urandom_range(3),
          $urandom_range(99) < 35, $urandom_range(1), $urandom_range(3), $urandom_range(3),
          $urandom);
    end
    idle(); idle(); idle();
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not end actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule